// File: doc/BRIEF.md
# Receive FIFO Top-Read Sequencer

This block gives software one 32-bit read window onto the oldest message in a receive FIFO kept in message RAM. Every read returns the RAM word at the current top address, one cycle after the request. If the read qualifies as a side-effect read, the block advances a word-within-message counter and the top address. The address wraps back to the start of the FIFO region when it runs past the region's end. A side-effect read of the final word of a message acknowledges that message: the block emits a single-cycle strobe that carries the message's get index. The FIFO bookkeeping uses that strobe to release the element.

The control is a four-state machine:
- IDLE: the feature is off, and reads return zero.
- LOAD: the top address is computed as start + get index × element words, and the word counter is cleared.
- READY: reads are served.
- ACK: the acknowledge strobe is driven.

Its transitions are:
- enable (IDLE→LOAD);
- loaded (LOAD→READY);
- last-word read (READY→ACK);
- reload (ACK→LOAD);
- disable (LOAD, READY or ACK→IDLE).

A side-effect read needs all of the following:
- the machine is in READY;
- the request is not a debug access;
- the controller is not in configuration mode;
- the fill level is nonzero.

Top module: `rx_fifo_top_reader`

## Requirements
- R1: Out of reset, `rd_data` is zero and `ack_valid` is low.
- R2: With `tp_en` high, a read request loads `rd_data`, at the following clock edge, with the RAM word at the address shown on `ram_addr` during the request. Successive side-effect reads within a message step `ram_addr` up by one word each.
- R3: Two clock edges after `tp_en` rises, `ram_addr` equals `fifo_start + get_idx × element_words`.
- R4: `element_words` is 2 header words plus payload words. The payload depends on `dsize_code` as follows:

| `dsize_code` | Payload words |
|---|---|
| 0 | 2 |
| 1 | 3 |
| 2 | 4 |
| 3 | 5 |
| 4 | 6 |
| 5 | 8 |
| 6 | 12 |
| 7 | 16 |

- R5: A side-effect read of the last word of a message raises `ack_valid` for exactly one cycle, in the cycle after the read, with `ack_idx` equal to the get index of that message. Other reads leave `ack_valid` low. Three cycles after that read, `ram_addr` has been reloaded from the updated get index.
- R6: When the top address steps past `fifo_start + fifo_size × element_words − 1`, it becomes `fifo_start`.
- R7: A read while `cfg_mode` is high returns data but leaves `ram_addr` unchanged.
- R8: A read while `fill_lvl` is zero returns data but leaves `ram_addr` unchanged.
- R9: A read with `rd_dbg` high returns data but leaves `ram_addr` unchanged.
- R10: With `tp_en` low, a read returns zero and leaves `ram_addr` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_req | input | 1 | Data-window read request, one cycle per read |
| rd_dbg | input | 1 | Marks the read as coming from the debug host |
| rd_data | output | 32 | Registered read data |
| cfg_mode | input | 1 | Controller in configuration mode |
| tp_en | input | 1 | Top-pointer feature enable |
| fill_lvl | input | IDX_W+1 | FIFO fill level |
| get_idx | input | IDX_W | FIFO get index |
| fifo_start | input | ADDR_W | FIFO region start word address |
| fifo_size | input | IDX_W+1 | FIFO size in elements |
| dsize_code | input | 3 | Element payload size code |
| ram_addr | output | ADDR_W | Message RAM word address (current top address) |
| ram_rdata | input | 32 | Message RAM word, combinational from `ram_addr` |
| ack_valid | output | 1 | Acknowledge strobe |
| ack_idx | output | IDX_W | Index being acknowledged |

## Verification
- **Read data:** `rd_data` appears one edge after the request, so the bench samples it at the falling edge that follows.
- **Address step:** the new top address is also visible on `ram_addr` at that same falling edge.
- **Acknowledge:** `ack_valid` is checked at that same falling edge.
- **Reload:** the reloaded address is due two further edges later, one for ACK→LOAD and one for the load itself, and is checked at the falling edge after that.
- **Enable:** after `tp_en` rises, the bench waits two falling edges before comparing `ram_addr` with the computed base.

Inputs change only on falling edges, so no check races a rising edge.

// File: rtl/rxtop_pkg.sv
package rxtop_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_READY,
        ST_ACK
    } rxtop_state_e;

    localparam int unsigned EW_W = 5;

    // Two header words plus payload words selected by the size code.
    function automatic logic [EW_W-1:0] elem_words(input logic [2:0] code);
        logic [EW_W-1:0] pay;
        unique case (code)
            3'd0: pay = 5'd2;
            3'd1: pay = 5'd3;
            3'd2: pay = 5'd4;
            3'd3: pay = 5'd5;
            3'd4: pay = 5'd6;
            3'd5: pay = 5'd8;
            3'd6: pay = 5'd12;
            3'd7: pay = 5'd16;
        endcase
        return pay + 5'd2;
    endfunction

endpackage

// File: rtl/rxtop_geom.sv
module rxtop_geom
    import rxtop_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned IDX_W  = 6
) (
    input  logic [2:0]        dsize_code,
    input  logic [ADDR_W-1:0] fifo_start,
    input  logic [IDX_W:0]    fifo_size,
    input  logic [IDX_W-1:0]  get_idx,
    output logic [EW_W-1:0]   last_word,
    output logic [ADDR_W-1:0] base_addr,
    output logic [ADDR_W:0]   end_addr
);
    localparam int unsigned SUM_W  = ADDR_W + 1;
    localparam int unsigned PROD_W = IDX_W + 1 + EW_W;

    logic [EW_W-1:0]   ew;
    logic [PROD_W-1:0] idx_off;
    logic [PROD_W-1:0] span;
    logic [SUM_W-1:0]  base_sum;

    always_comb begin
        ew        = elem_words(dsize_code);
        last_word = ew - EW_W'(1);
        idx_off   = PROD_W'(get_idx) * PROD_W'(ew);
        span      = PROD_W'(fifo_size) * PROD_W'(ew);
        base_sum  = SUM_W'(fifo_start) + SUM_W'(idx_off);
        base_addr = base_sum[ADDR_W-1:0];
        end_addr  = SUM_W'(fifo_start) + SUM_W'(span);
    end

endmodule

// File: rtl/rxtop_fsm.sv
module rxtop_fsm
    import rxtop_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tp_en,
    input  logic         se_ok,
    input  logic         at_last,
    output rxtop_state_e state,
    output logic         load,
    output logic         step,
    output logic         ack_valid
);
    rxtop_state_e nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt       = state;
        load      = 1'b0;
        step      = 1'b0;
        ack_valid = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (tp_en) nxt = ST_LOAD;
            end
            ST_LOAD: begin
                load = tp_en;
                nxt  = tp_en ? ST_READY : ST_IDLE;
            end
            ST_READY: begin
                if (!tp_en) begin
                    nxt = ST_IDLE;
                end else if (se_ok) begin
                    step = 1'b1;
                    if (at_last) nxt = ST_ACK;
                end
            end
            ST_ACK: begin
                ack_valid = 1'b1;
                nxt       = tp_en ? ST_LOAD : ST_IDLE;
            end
        endcase
    end

    // R5: the acknowledge strobe lasts exactly one cycle
    p_ack_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |=> !ack_valid);

    // R5: an acknowledge is always followed by a reload or disable
    p_ack_then_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACK && tp_en) |=> state == ST_LOAD);

    // R10: dropping the enable leaves the serving state
    p_disable_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_READY && !tp_en) |=> state == ST_IDLE);

endmodule

// File: rtl/rxtop_ptr.sv
module rxtop_ptr
    import rxtop_pkg::*;
#(
    parameter int unsigned ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [ADDR_W:0]   end_addr,
    input  logic [ADDR_W-1:0] fifo_start,
    input  logic [EW_W-1:0]   last_word,
    output logic [ADDR_W-1:0] top_addr,
    output logic [EW_W-1:0]   wcnt,
    output logic              at_last
);
    localparam int unsigned SUM_W = ADDR_W + 1;

    logic [SUM_W-1:0] inc;

    assign at_last = (wcnt == last_word);
    assign inc     = SUM_W'(top_addr) + SUM_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_addr <= '0;
            wcnt     <= '0;
        end else if (load) begin
            top_addr <= base_addr;
            wcnt     <= '0;
        end else if (step) begin
            top_addr <= (inc == end_addr) ? fifo_start : inc[ADDR_W-1:0];
            wcnt     <= at_last ? '0 : wcnt + EW_W'(1);
        end
    end

    // R3: a load places the base address and clears the word counter
    p_load_base_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (top_addr == $past(base_addr) && wcnt == '0));

    // R2: a mid-message step advances the word counter by one
    p_step_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !at_last) |=> wcnt == $past(wcnt) + EW_W'(1));

    // R5: the last word restarts the word counter
    p_last_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (step && at_last) |=> wcnt == '0);

endmodule

// File: rtl/rx_fifo_top_reader.sv
module rx_fifo_top_reader
    import rxtop_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned IDX_W  = 6,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic              rd_dbg,
    output logic [DATA_W-1:0] rd_data,
    input  logic              cfg_mode,
    input  logic              tp_en,
    input  logic [IDX_W:0]    fill_lvl,
    input  logic [IDX_W-1:0]  get_idx,
    input  logic [ADDR_W-1:0] fifo_start,
    input  logic [IDX_W:0]    fifo_size,
    input  logic [2:0]        dsize_code,
    output logic [ADDR_W-1:0] ram_addr,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic              ack_valid,
    output logic [IDX_W-1:0]  ack_idx
);
    rxtop_state_e      state;
    logic              load;
    logic              step;
    logic              at_last;
    logic              se_ok;
    logic [EW_W-1:0]   last_word;
    logic [EW_W-1:0]   wcnt;
    logic [ADDR_W-1:0] base_addr;
    logic [ADDR_W:0]   end_addr;
    logic [ADDR_W-1:0] top_addr;
    logic [IDX_W-1:0]  ack_idx_q;

    assign se_ok    = rd_req && !rd_dbg && !cfg_mode && (fill_lvl != '0);
    assign ram_addr = top_addr;
    assign ack_idx  = ack_idx_q;

    rxtop_geom #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_geom (
        .dsize_code (dsize_code),
        .fifo_start (fifo_start),
        .fifo_size  (fifo_size),
        .get_idx    (get_idx),
        .last_word  (last_word),
        .base_addr  (base_addr),
        .end_addr   (end_addr)
    );

    rxtop_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tp_en     (tp_en),
        .se_ok     (se_ok),
        .at_last   (at_last),
        .state     (state),
        .load      (load),
        .step      (step),
        .ack_valid (ack_valid)
    );

    rxtop_ptr #(.ADDR_W(ADDR_W)) u_ptr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .step       (step),
        .base_addr  (base_addr),
        .end_addr   (end_addr),
        .fifo_start (fifo_start),
        .last_word  (last_word),
        .top_addr   (top_addr),
        .wcnt       (wcnt),
        .at_last    (at_last)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data   <= '0;
            ack_idx_q <= '0;
        end else begin
            if (rd_req)           rd_data   <= tp_en ? ram_rdata : '0;
            if (step && at_last)  ack_idx_q <= get_idx;
        end
    end

    // R10: a read with the feature off returns zero
    p_off_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !tp_en) |=> rd_data == '0);

    // R9: a debug read never moves the top address
    p_dbg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_READY && rd_dbg) |=> $stable(ram_addr));

    // R8: an empty FIFO never moves the top address
    p_empty_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_READY && fill_lvl == '0) |=> $stable(ram_addr));

    // R7: configuration mode never moves the top address
    p_cfg_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_READY && cfg_mode) |=> $stable(ram_addr));

    // R5: the strobe carries the index of the message just finished
    p_ack_index_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (step && at_last) |=> (ack_valid && ack_idx == $past(get_idx)));

endmodule

// File: tb/rx_fifo_top_reader_tb.sv
module rx_fifo_top_reader_tb;
    localparam int unsigned ADDR_W = 12;
    localparam int unsigned IDX_W  = 6;

    // {dsize_code[27:25], start[24:13], size[12:6], get_idx[5:0]}
    localparam logic [27:0] VEC [4] = '{
        {3'd0, 12'h100, 7'd4, 6'd1},
        {3'd5, 12'h200, 7'd3, 6'd2},
        {3'd7, 12'h040, 7'd2, 6'd0},
        {3'd3, 12'h300, 7'd5, 6'd4}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              rd_req = 1'b0;
    logic              rd_dbg = 1'b0;
    logic [31:0]       rd_data;
    logic              cfg_mode = 1'b0;
    logic              tp_en = 1'b0;
    logic [IDX_W:0]    fill_lvl = '0;
    logic [IDX_W-1:0]  get_idx = '0;
    logic [ADDR_W-1:0] fifo_start = '0;
    logic [IDX_W:0]    fifo_size = 7'd1;
    logic [2:0]        dsize_code = '0;
    logic [ADDR_W-1:0] ram_addr;
    logic [31:0]       ram_rdata;
    logic              ack_valid;
    logic [IDX_W-1:0]  ack_idx;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    assign ram_rdata = 32'h5A00_0000 | {20'd0, ram_addr};

    rx_fifo_top_reader u_dut (
        .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_dbg(rd_dbg),
        .rd_data(rd_data), .cfg_mode(cfg_mode), .tp_en(tp_en),
        .fill_lvl(fill_lvl), .get_idx(get_idx), .fifo_start(fifo_start),
        .fifo_size(fifo_size), .dsize_code(dsize_code), .ram_addr(ram_addr),
        .ram_rdata(ram_rdata), .ack_valid(ack_valid), .ack_idx(ack_idx)
    );

    function automatic int ew_of(input logic [2:0] c);
        int pay [8] = '{2, 3, 4, 5, 6, 8, 12, 16};
        return pay[c] + 2;
    endfunction

    function automatic logic [31:0] word_at(input int a);
        return 32'h5A00_0000 | (a & 12'hFFF);
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Called at a falling edge: one-cycle read, returns at the next falling edge.
    task automatic do_read(input bit dbg);
        rd_req = 1'b1;
        rd_dbg = dbg;
        @(negedge clk);
        rd_req = 1'b0;
        rd_dbg = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog all-requirements actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(rd_data == 0, "R1 rd_data at reset", rd_data, 0);
        check(ack_valid == 0, "R1 ack_valid at reset", ack_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(rd_data == 0 && !ack_valid, "R1 after release", rd_data, 0);

        for (int v = 0; v < 4; v++) begin
            int ew, st, sz, gi, base, ea, nxt;
            tp_en = 1'b0;
            repeat (2) @(negedge clk);
            dsize_code = VEC[v][27:25];
            fifo_start = VEC[v][24:13];
            fifo_size  = VEC[v][12:6];
            get_idx    = VEC[v][5:0];
            fill_lvl   = 7'd2;
            ew = ew_of(VEC[v][27:25]);
            st = VEC[v][24:13];
            sz = VEC[v][12:6];
            gi = VEC[v][5:0];
            base = st + gi * ew;
            tp_en = 1'b1;
            repeat (2) @(negedge clk);
            check(ram_addr == base[11:0], "R3 R4 base address", ram_addr, base);
            for (int k = 0; k < ew; k++) begin
                ea = base + k;
                do_read(1'b0);
                check(rd_data == word_at(ea), "R2 read word", rd_data, word_at(ea));
                if (k < ew - 1) begin
                    check(ram_addr == ea + 1, "R2 address step", ram_addr, ea + 1);
                    check(!ack_valid, "R5 no ack mid-message", ack_valid, 0);
                end
            end
            nxt = base + ew;
            if (nxt == st + sz * ew) nxt = st;
            check(ram_addr == nxt[11:0], "R6 address after last word", ram_addr, nxt);
            check(ack_valid && ack_idx == gi[5:0], "R5 ack strobe and index",
                  {ack_valid, ack_idx}, {1'b1, gi[5:0]});
            gi = (gi + 1) % sz;
            get_idx  = gi[5:0];
            fill_lvl = fill_lvl - 1;
            @(negedge clk);
            check(!ack_valid, "R5 ack lasts one cycle", ack_valid, 0);
            @(negedge clk);
            check(ram_addr == (st + gi * ew), "R5 reload from new index", ram_addr, st + gi * ew);
        end

        // Directed gating cases on the first geometry.
        tp_en = 1'b0;
        repeat (2) @(negedge clk);
        dsize_code = 3'd0; fifo_start = 12'h100; fifo_size = 7'd4;
        get_idx = 6'd1; fill_lvl = 7'd2; tp_en = 1'b1;
        repeat (2) @(negedge clk);

        do_read(1'b1);
        check(rd_data == word_at(12'h104), "R9 debug read data", rd_data, word_at(12'h104));
        check(ram_addr == 12'h104, "R9 debug read no step", ram_addr, 12'h104);

        cfg_mode = 1'b1;
        do_read(1'b0);
        cfg_mode = 1'b0;
        check(rd_data == word_at(12'h104), "R7 config read data", rd_data, word_at(12'h104));
        check(ram_addr == 12'h104, "R7 config read no step", ram_addr, 12'h104);

        fill_lvl = 7'd0;
        do_read(1'b0);
        check(ram_addr == 12'h104, "R8 empty read no step", ram_addr, 12'h104);
        check(!ack_valid, "R8 empty read no ack", ack_valid, 0);
        fill_lvl = 7'd2;

        do_read(1'b0);
        check(ram_addr == 12'h105, "R2 normal read steps", ram_addr, 12'h105);

        tp_en = 1'b0;
        repeat (2) @(negedge clk);
        do_read(1'b0);
        check(rd_data == 0, "R10 disabled read zero", rd_data, 0);
        check(ram_addr == 12'h105, "R10 disabled read no step", ram_addr, 12'h105);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule